// File: doc/BRIEF.md
# Shadow Stack Return Checker

This block keeps a protected second copy of every return address for a simple in-order core. It watches retired call and return events. On a call it stores the return address in an internal shadow memory. On a return it takes the newest stored address and compares it with the address the core popped from its ordinary data stack. When the two addresses agree, the block signals that the return is valid. When they differ, or when the shadow stack cannot take the operation, it raises a control-protection fault with a reason code.

Each of the four privilege levels (0 is the most privileged and 3 the least) has its own shadow stack region and its own top-of-stack pointer. The current privilege input selects which pointer is active. The shadow memory accepts only return addresses. The pointers are reached only through a management port: it always reads the active pointer, and it loads the pointer only while the privileged-mode input is high.

Each region holds `DEPTH` entries, and `DEPTH` must be a power of two. A pointer holds the index of the current top entry. The stack grows downward. An empty stack has its pointer equal to `DEPTH`, and a full stack has its pointer equal to 0.

Top module: `shstk_guard`

## Requirements
- R1: A call event with the active pointer above 0 decrements that pointer by one and stores `call_addr` at the new top entry.
- R2: A return event on a non-empty stack compares the top entry with `ret_addr`. When they match, the active pointer increments by one and `ret_ok` is high for exactly the next cycle.
- R3: A return whose top entry differs from `ret_addr` sets `fault` high for the next cycle with `fault_code` = 1 (mismatch). `ret_ok` stays low and no pointer changes.
- R4: A return while the active pointer equals `DEPTH` (stack empty) raises `fault` with `fault_code` = 2 (underflow), and the pointer is left unchanged.
- R5: A call while the active pointer is 0 (stack full) raises `fault` with `fault_code` = 3 (overflow). Neither the pointer nor the stored entries change.
- R6: There are four independent pointers and regions, one per privilege level. `cur_pl` selects the active one, and events never touch the other three.
- R7: `mgmt_rdata` always shows the active pointer. A `mgmt_load` with `mgmt_priv` high writes `mgmt_wdata` into the active pointer (values above `DEPTH` are clamped to `DEPTH`) and overrides any event in the same cycle. A `mgmt_load` with `mgmt_priv` low has no effect.
- R8: `fault` is a one-cycle pulse for each faulting event. `fault_code` is registered together with it and keeps its value until the next fault.
- R9: After reset every pointer equals `DEPTH`, and `ret_ok`, `fault` and `fault_code` are 0.
- R10: When a call and a return occur in the same cycle, only the call is performed and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pl | input | 2 | Current privilege level, selects the active pointer |
| call_vld | input | 1 | A call instruction retired |
| call_addr | input | AW | Return address pushed by that call |
| ret_vld | input | 1 | A return instruction retired |
| ret_addr | input | AW | Return address the core popped from its data stack |
| mgmt_priv | input | 1 | Core is in privileged mode |
| mgmt_load | input | 1 | Management command: load the active pointer |
| mgmt_wdata | input | PW | Value to load into the active pointer |
| mgmt_rdata | output | PW | Current value of the active pointer |
| ret_ok | output | 1 | Return validated (one-cycle pulse) |
| fault | output | 1 | Control-protection fault (one-cycle pulse) |
| fault_code | output | 2 | Fault reason: 1 mismatch, 2 underflow, 3 overflow |

## Verification
The bound checker checks these on every cycle:
- `ret_ok` and `fault` are never high together, and a fault never carries code 0.
- No pointer ever exceeds `DEPTH`.
- A pointer never moves in the cycle a fault is reported, or when no privileged load and no event is present.
- An empty-stack return always yields the underflow code, and a full-stack call always yields the overflow code.

Only the bench's scenarios can show the rest:
- Stored addresses come back in last-in-first-out order.
- A mismatched address is caught.
- The four privilege-level regions stay separate.
- An unprivileged load leaves the pointer unchanged.
- A call and a return in the same cycle are resolved in favour of the call.

// File: rtl/shstk_guard.sv
module shstk_guard #(
  parameter int AW    = 32,
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH),
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cur_pl,
  input  logic          call_vld,
  input  logic [AW-1:0] call_addr,
  input  logic          ret_vld,
  input  logic [AW-1:0] ret_addr,
  input  logic          mgmt_priv,
  input  logic          mgmt_load,
  input  logic [PW-1:0] mgmt_wdata,
  output logic [PW-1:0] mgmt_rdata,
  output logic          ret_ok,
  output logic          fault,
  output logic [1:0]    fault_code
);
  localparam logic [PW-1:0] BASE = PW'(DEPTH);
  localparam logic [1:0] C_MISMATCH  = 2'd1;
  localparam logic [1:0] C_UNDERFLOW = 2'd2;
  localparam logic [1:0] C_OVERFLOW  = 2'd3;

  logic [3:0][PW-1:0] sp;
  logic [AW-1:0] mem [4*DEPTH];

  wire [PW-1:0] top     = sp[cur_pl];
  wire          empty   = (top == BASE);
  wire          full    = (top == '0);
  wire          load_go = mgmt_load & mgmt_priv;
  wire          do_call = call_vld & ~load_go;
  wire          do_ret  = ret_vld & ~call_vld & ~load_go;
  wire [PW-1:0] dec     = top - 1'b1;
  wire [LW-1:0] push_ix = dec[LW-1:0];
  wire [LW-1:0] top_ix  = top[LW-1:0];
  wire          match   = (mem[{cur_pl, top_ix}] == ret_addr);
  wire [PW-1:0] ld_val  = (mgmt_wdata > BASE) ? BASE : mgmt_wdata;

  assign mgmt_rdata = top;

  always_ff @(posedge clk)
    if (do_call && !full) mem[{cur_pl, push_ix}] <= call_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) sp[i] <= BASE;
      ret_ok     <= 1'b0;
      fault      <= 1'b0;
      fault_code <= '0;
    end else begin
      ret_ok <= 1'b0;
      fault  <= 1'b0;
      if (load_go) begin
        sp[cur_pl] <= ld_val;
      end else if (do_call) begin
        if (full) begin
          fault      <= 1'b1;
          fault_code <= C_OVERFLOW;
        end else begin
          sp[cur_pl] <= dec;
        end
      end else if (do_ret) begin
        if (empty) begin
          fault      <= 1'b1;
          fault_code <= C_UNDERFLOW;
        end else if (match) begin
          sp[cur_pl] <= top + 1'b1;
          ret_ok     <= 1'b1;
        end else begin
          fault      <= 1'b1;
          fault_code <= C_MISMATCH;
        end
      end
    end
  end
endmodule

// File: rtl/shstk_guard_chk.sv
module shstk_guard_chk #(
  parameter int DEPTH = 16,
  parameter int PW    = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         cur_pl,
  input logic               call_vld,
  input logic               ret_vld,
  input logic               mgmt_priv,
  input logic               mgmt_load,
  input logic               ret_ok,
  input logic               fault,
  input logic [1:0]         fault_code,
  input logic [3:0][PW-1:0] sp
);
  localparam logic [PW-1:0] BASE = PW'(DEPTH);
  wire load_go = mgmt_load & mgmt_priv;

  assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ret_ok && fault));

  assert_code_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> fault_code != 2'd0);

  assert_hold_on_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $stable(sp));

  assert_no_event_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!call_vld && !ret_vld && !load_go) |=> $stable(sp));

  assert_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld && !call_vld && !load_go && sp[cur_pl] == BASE) |=> (fault && fault_code == 2'd2));

  assert_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (call_vld && !load_go && sp[cur_pl] == '0) |=> (fault && fault_code == 2'd3));

  for (genvar g = 0; g < 4; g++) begin : g_bound
    assert_ptr_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sp[g] <= BASE);
  end
endmodule

bind shstk_guard shstk_guard_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cur_pl(cur_pl), .call_vld(call_vld),
  .ret_vld(ret_vld), .mgmt_priv(mgmt_priv), .mgmt_load(mgmt_load),
  .ret_ok(ret_ok), .fault(fault), .fault_code(fault_code), .sp(sp)
);

// File: tb/shstk_guard_bench.sv
module shstk_guard_bench;
  localparam int AW = 32;
  localparam int D  = 16;
  localparam int PW = $clog2(D + 1);

  logic          clk = 0;
  logic          rst_n = 0;
  logic [1:0]    cur_pl = 0;
  logic          call_vld = 0, ret_vld = 0, mgmt_priv = 0, mgmt_load = 0;
  logic [AW-1:0] call_addr = 0, ret_addr = 0;
  logic [PW-1:0] mgmt_wdata = 0;
  logic [PW-1:0] mgmt_rdata;
  logic          ret_ok, fault;
  logic [1:0]    fault_code;

  always #5 clk = ~clk;

  shstk_guard #(.AW(AW), .DEPTH(D)) u_shstk_guard (
    .clk(clk), .rst_n(rst_n), .cur_pl(cur_pl), .call_vld(call_vld),
    .call_addr(call_addr), .ret_vld(ret_vld), .ret_addr(ret_addr),
    .mgmt_priv(mgmt_priv), .mgmt_load(mgmt_load), .mgmt_wdata(mgmt_wdata),
    .mgmt_rdata(mgmt_rdata), .ret_ok(ret_ok), .fault(fault), .fault_code(fault_code)
  );

  int checks = 0, fails = 0;
  int msp [4];
  logic [AW-1:0] mm [4][D];
  logic [1:0] last_code = 0;
  logic [3:0] exp_q [$];
  string      tag_q [$];
  logic       running = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (running && exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({ret_ok, fault, fault_code} == e, t, int'({ret_ok, fault, fault_code}), int'(e));
    end
  end

  task automatic step(input logic [1:0] pl, input bit c, input logic [AW-1:0] ca,
                      input bit r, input logic [AW-1:0] ra, input bit pv, input bit ld,
                      input int wd, input string tag);
    bit ok, f;
    logic [1:0] code;
    @(negedge clk);
    cur_pl = pl; call_vld = c; call_addr = ca; ret_vld = r; ret_addr = ra;
    mgmt_priv = pv; mgmt_load = ld; mgmt_wdata = PW'(wd);
    #1;
    chk(mgmt_rdata == PW'(msp[pl]), "R7 read", int'(mgmt_rdata), msp[pl]);
    ok = 0; f = 0; code = 0;
    if (ld && pv) msp[pl] = (wd > D) ? D : wd;
    else if (c) begin
      if (msp[pl] == 0) begin f = 1; code = 3; end
      else begin msp[pl]--; mm[pl][msp[pl]] = ca; end
    end else if (r) begin
      if (msp[pl] == D) begin f = 1; code = 2; end
      else if (mm[pl][msp[pl]] == ra) begin ok = 1; msp[pl]++; end
      else begin f = 1; code = 1; end
    end
    if (f) last_code = code;
    exp_q.push_back({ok, f, last_code});
    tag_q.push_back(tag);
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0, "R8 idle"); endtask
  task automatic call(input logic [1:0] pl, input logic [AW-1:0] a, input string t);
    step(pl, 1, a, 0, 0, 0, 0, 0, t);
  endtask
  task automatic ret(input logic [1:0] pl, input logic [AW-1:0] a, input string t);
    step(pl, 0, 0, 1, a, 0, 0, 0, t);
  endtask

  initial begin
    #500us;
    fails++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) msp[i] = D;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({ret_ok, fault, fault_code} == 4'b0, "R9 outputs", int'({ret_ok, fault, fault_code}), 0);
    for (int i = 0; i < 4; i++) begin
      cur_pl = 2'(i); #1;
      chk(mgmt_rdata == PW'(D), "R9 pointer", int'(mgmt_rdata), D);
    end
    running = 1;
    call(0, 32'h1000, "R1 push a");
    call(0, 32'h2000, "R1 push b");
    call(0, 32'h3000, "R1 push c");
    ret(0, 32'h3000, "R2 pop c");
    ret(0, 32'h2000, "R2 pop b");
    ret(0, 32'hDEAD, "R3 mismatch");
    idle();
    ret(0, 32'hBEEF, "R3 mismatch again");
    ret(0, 32'h1000, "R2 pop a");
    ret(0, 32'h1000, "R4 underflow");
    idle();
    for (int k = 0; k < D; k++) call(1, 32'h4000 + 32'(k), "R1 fill");
    call(1, 32'hFFFF, "R5 overflow");
    ret(1, 32'h4000 + 32'(D - 1), "R5 top intact");
    call(2, 32'hAAAA, "R6 level2");
    call(3, 32'hBBBB, "R6 level3");
    ret(2, 32'hAAAA, "R6 level2 pop");
    ret(3, 32'hBBBB, "R6 level3 pop");
    step(0, 0, 0, 0, 0, 0, 1, 3, "R7 unpriv load");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R7 after unpriv");
    step(0, 0, 0, 0, 0, 1, 1, 7, "R7 priv load");
    step(0, 1, 32'h5, 0, 0, 1, 1, 31, "R7 load clamps over call");
    step(0, 1, 32'h7777, 1, 32'h1, 0, 0, 0, "R10 call wins");
    ret(0, 32'h7777, "R10 pushed value");
    idle(); idle();
    @(negedge clk);
    running = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule